// File: doc/BRIEF.md
# DMA Engine Control Register Bank

This block holds the control registers that a host uses to configure and kick the transmit and receive DMA engines of a network controller. It sits between a simple register read/write port and the two engines. Each engine reports its state as stopped, running or suspended. The bank uses those states to decide whether a host write may take effect.

The bus-configuration register holds four things:
- buffer byte order,
- the gap between consecutive descriptors, counted in 32-bit words,
- which engine wins bus arbitration,
- a software-reset bit that clears itself.

Two kick registers turn host writes into single-cycle start pulses for a suspended engine. Two base registers hold the word-aligned start addresses of the descriptor rings.

A write that arrives while its engine is in the wrong state is dropped. The bank then raises a one-cycle rejection flag.

Top module: `dma_csr_bank`

## Requirements
- R1: After synchronous reset, all of the following are 0: `big_endian`, `skip_len`, `tx_priority`, both descriptor bases, `soft_reset`, `tx_kick`, `rx_kick` and `wr_reject`.
- R2: A write to offset 00h updates the configuration fields on the next clock. It is accepted only while both engines are stopped (state 2'b00) and no soft reset is in progress. The field positions are:
  - bit 7 → `big_endian`
  - bits 6:2 → `skip_len`
  - bit 1 → `tx_priority`
  
  Otherwise the fields keep their values.
- R3: An accepted offset-00h write with bit 0 set drives `soft_reset` high for exactly 16 cycles, starting on the next clock. Bit 0 of offset 00h reads as 1 during that window and as 0 afterwards. Offset-00h writes made during the window are rejected.
- R4: A soft reset leaves the configuration fields and the descriptor bases unchanged.
- R5: A write of any value to offset 08h while the transmit engine is suspended (state 2'b10) makes `tx_kick` high for exactly the next cycle.
- R6: A write of any value to offset 10h while the receive engine is suspended makes `rx_kick` high for exactly the next cycle.
- R7: Offsets 08h and 10h always read as FFFFFFFFh.
- R8: The receive base is at offset 18h and the transmit base is at offset 20h. Each stores write-data bits 31:2 and reads bits 1:0 as 0. A write is accepted only while the matching engine is stopped.
- R9: Any write to a mapped offset that is not accepted raises `wr_reject` for exactly the next cycle. An accepted write leaves it low.
- R10: An offset outside the five mapped offsets reads as 0. A write to it changes no register and raises no `wr_reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_state | input | 2 | Transmit engine state: 00 stopped, 01 running, 10 suspended |
| rx_state | input | 2 | Receive engine state, same encoding |
| big_endian | output | 1 | Data-buffer byte order, 1 = big endian |
| skip_len | output | 5 | Descriptor gap in 32-bit words |
| tx_priority | output | 1 | 1 = transmit wins arbitration, 0 = receive wins |
| rx_desc_base | output | 32 | Receive descriptor ring start address |
| tx_desc_base | output | 32 | Transmit descriptor ring start address |
| soft_reset | output | 1 | Software reset pulse to the engines |
| tx_kick | output | 1 | One-cycle start pulse to the transmit engine |
| rx_kick | output | 1 | One-cycle start pulse to the receive engine |
| wr_reject | output | 1 | One-cycle flag for a dropped write |

## Verification
Some wrong internal states show up on the ports one clock after the offending write:
- a bad acceptance decision shows as a configuration or base output that changes when it must hold, or that holds when it must change;
- a wrong kick or rejection flag shows as a misplaced one-cycle pulse.

A wrong reset-window count stays hidden until the window closes. It then shows as `soft_reset` falling early or late, and as a mismatch in bit 0 of the offset-00h readback. The bench compares every output and the read data of the addressed register against its model on every cycle, so any such divergence is caught in the cycle where it first appears.

// File: rtl/dma_csr_pkg.sv
// Shared types and offsets for the DMA control register bank.
// Assumes engines report their state with the 2-bit code below.
package dma_csr_pkg;

    typedef enum logic [1:0] {
        ENG_STOPPED   = 2'b00,
        ENG_RUNNING   = 2'b01,
        ENG_SUSPENDED = 2'b10,
        ENG_RESERVED  = 2'b11
    } eng_state_e;

    localparam logic [7:0] OFS_BUSCFG  = 8'h00;
    localparam logic [7:0] OFS_TX_KICK = 8'h08;
    localparam logic [7:0] OFS_RX_KICK = 8'h10;
    localparam logic [7:0] OFS_RX_BASE = 8'h18;
    localparam logic [7:0] OFS_TX_BASE = 8'h20;

    localparam int SKIP_W = 5;

    typedef struct packed {
        logic              big_endian;
        logic [SKIP_W-1:0] skip_len;
        logic              tx_priority;
    } buscfg_t;

endpackage

// File: rtl/dma_csr_buscfg.sv
// Bus-configuration register plus the self-timed software reset.
// Accepts a write only while both engines are stopped and no reset
// window is open; a set bit 0 opens a RST_CYCLES-long reset window.
module dma_csr_buscfg
    import dma_csr_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [7:0] wdata,
    input  logic       both_stopped,
    output buscfg_t    cfg_o,
    output logic       soft_reset_o,
    output logic       reject_o
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_CYCLES);

    logic [CNT_W-1:0] rst_cnt;
    logic             accept;

    // Acceptance rule for a configuration write
    always_comb begin
        accept   = wr_hit && both_stopped && (rst_cnt == '0);
        reject_o = wr_hit && !accept;
    end

    // Configuration fields load from an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_o <= '0;
        else if (accept)
            cfg_o <= '{big_endian: wdata[7], skip_len: wdata[6:2], tx_priority: wdata[1]};
    end

    // Reset window counter: load on request, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_cnt <= '0;
        else if (accept && wdata[0])
            rst_cnt <= RST_LOAD;
        else if (rst_cnt != '0)
            rst_cnt <= rst_cnt - 1'b1;
    end

    assign soft_reset_o = (rst_cnt != '0);

    // R2: fields hold when engines are not both stopped
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !both_stopped) |=> $stable(cfg_o));

    // R3: a reset window only opens after a write carrying bit 0
    p_rst_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_reset_o) |-> $past(wr_hit && wdata[0]));

    // R4: the reset window never touches the configuration fields
    p_rst_keeps_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_reset_o && !wr_hit) |=> $stable(cfg_o));

endmodule

// File: rtl/dma_csr_kick.sv
// Kick register: a write of any value while the engine is suspended
// becomes a one-cycle start pulse on the following clock.
module dma_csr_kick
    import dma_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [1:0] eng_state,
    output logic       kick_o,
    output logic       reject_o
);
    logic accept;

    // Acceptance rule for a kick write
    always_comb begin
        accept   = wr_hit && (eng_state == ENG_SUSPENDED);
        reject_o = wr_hit && !accept;
    end

    // Register the start pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            kick_o <= 1'b0;
        else
            kick_o <= accept;
    end

    // R5: a pulse always traces back to a write seen in the suspended state
    p_kick_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |-> $past(wr_hit && eng_state == ENG_SUSPENDED));

    // R6: without a write there is no pulse next cycle
    p_kick_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> !kick_o);

endmodule

// File: rtl/dma_csr_base.sv
// Descriptor ring base register: keeps address bits 31:2 and reads the
// low two bits as zero. A write lands only while the engine is stopped.
module dma_csr_base
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [1:0]        eng_state,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base_o,
    output logic              reject_o
);
    localparam int KEEP_W = ADDR_W - 2;

    logic [KEEP_W-1:0] base_q;
    logic              accept;

    // Acceptance rule for a base write
    always_comb begin
        accept   = wr_hit && (eng_state == ENG_STOPPED);
        reject_o = wr_hit && !accept;
    end

    // Store the word-aligned part of the address
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (accept)
            base_q <= wdata[ADDR_W-1:2];
    end

    assign base_o = {base_q, 2'b00};

    // R8: base holds while the engine is not stopped
    p_base_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state != ENG_STOPPED) |=> $stable(base_o));

endmodule

// File: rtl/dma_csr_bank.sv
// Register bank between a host register port and the two DMA engines.
// Decodes offsets, gates writes on engine state, flags dropped writes
// and returns read data combinationally for the addressed offset.
module dma_csr_bank
    import dma_csr_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [1:0]  tx_state,
    input  logic [1:0]  rx_state,
    output logic        big_endian,
    output logic [4:0]  skip_len,
    output logic        tx_priority,
    output logic [31:0] rx_desc_base,
    output logic [31:0] tx_desc_base,
    output logic        soft_reset,
    output logic        tx_kick,
    output logic        rx_kick,
    output logic        wr_reject
);
    localparam int NENG = 2;   // index 0 = transmit, 1 = receive

    buscfg_t                 cfg;
    logic                    cfg_hit, cfg_rej, mapped;
    logic [NENG-1:0]         kick_hit, kick_rej, kick;
    logic [NENG-1:0]         base_hit, base_rej;
    logic [NENG-1:0][1:0]    eng;
    logic [NENG-1:0][31:0]   base;

    assign eng = {rx_state, tx_state};

    // Address decode of the write strobe
    always_comb begin
        cfg_hit     = reg_wr && (reg_addr == OFS_BUSCFG);
        kick_hit[0] = reg_wr && (reg_addr == OFS_TX_KICK);
        kick_hit[1] = reg_wr && (reg_addr == OFS_RX_KICK);
        base_hit[0] = reg_wr && (reg_addr == OFS_TX_BASE);
        base_hit[1] = reg_wr && (reg_addr == OFS_RX_BASE);
        mapped      = cfg_hit || (|kick_hit) || (|base_hit);
    end

    dma_csr_buscfg #(.RST_CYCLES(RST_CYCLES)) u_buscfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_hit       (cfg_hit),
        .wdata        (reg_wdata[7:0]),
        .both_stopped ((tx_state == ENG_STOPPED) && (rx_state == ENG_STOPPED)),
        .cfg_o        (cfg),
        .soft_reset_o (soft_reset),
        .reject_o     (cfg_rej)
    );

    for (genvar i = 0; i < NENG; i++) begin : g_eng
        dma_csr_kick u_kick (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (kick_hit[i]),
            .eng_state (eng[i]),
            .kick_o    (kick[i]),
            .reject_o  (kick_rej[i])
        );
        dma_csr_base #(.ADDR_W(32)) u_base (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (base_hit[i]),
            .eng_state (eng[i]),
            .wdata     (reg_wdata),
            .base_o    (base[i]),
            .reject_o  (base_rej[i])
        );
    end

    assign big_endian   = cfg.big_endian;
    assign skip_len     = cfg.skip_len;
    assign tx_priority  = cfg.tx_priority;
    assign tx_desc_base = base[0];
    assign rx_desc_base = base[1];
    assign tx_kick      = kick[0];
    assign rx_kick      = kick[1];

    // Register the dropped-write flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_reject <= 1'b0;
        else
            wr_reject <= cfg_rej || (|kick_rej) || (|base_rej);
    end

    // Read data mux for the addressed register
    always_comb begin
        case (reg_addr)
            OFS_BUSCFG:  reg_rdata = {24'h0, cfg.big_endian, cfg.skip_len, cfg.tx_priority, soft_reset};
            OFS_TX_KICK: reg_rdata = 32'hFFFF_FFFF;
            OFS_RX_KICK: reg_rdata = 32'hFFFF_FFFF;
            OFS_RX_BASE: reg_rdata = base[1];
            OFS_TX_BASE: reg_rdata = base[0];
            default:     reg_rdata = 32'h0;
        endcase
    end

    // R9: a rejection flag always follows a write strobe
    p_reject_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $past(reg_wr));

    // R10: writes to unmapped offsets never raise the flag
    p_unmapped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !mapped) |=> !wr_reject);

    // R7: kick offsets read all ones
    p_kick_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_TX_KICK || reg_addr == OFS_RX_KICK) |-> (reg_rdata == 32'hFFFF_FFFF));

endmodule

// File: tb/tb_dma_csr_bank.sv
// Bench: behavioural reference model updated at each rising edge,
// all outputs and the read data compared after each falling edge.
module tb_dma_csr_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  tx_state = 2'b00;
    logic [1:0]  rx_state = 2'b00;
    logic        big_endian, tx_priority, soft_reset, tx_kick, rx_kick, wr_reject;
    logic [4:0]  skip_len;
    logic [31:0] rx_desc_base, tx_desc_base;

    dma_csr_bank dut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int          m_cnt = 0;
    logic        m_be = 0, m_pr = 0, m_txk = 0, m_rxk = 0, m_rej = 0;
    logic [4:0]  m_skip = 0;
    logic [31:0] m_rxb = 0, m_txb = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_be = 0; m_pr = 0; m_skip = 0;
            m_rxb = 0; m_txb = 0; m_txk = 0; m_rxk = 0; m_rej = 0;
        end else begin
            logic rej;
            int   next_cnt;
            rej = 0; m_txk = 0; m_rxk = 0;
            next_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
            if (reg_wr) begin
                if (reg_addr == 8'h00) begin
                    if (tx_state == 0 && rx_state == 0 && m_cnt == 0) begin
                        m_be = reg_wdata[7]; m_skip = reg_wdata[6:2]; m_pr = reg_wdata[1];
                        if (reg_wdata[0]) next_cnt = 16;
                    end else rej = 1;
                end else if (reg_addr == 8'h08) begin
                    if (tx_state == 2) m_txk = 1; else rej = 1;
                end else if (reg_addr == 8'h10) begin
                    if (rx_state == 2) m_rxk = 1; else rej = 1;
                end else if (reg_addr == 8'h18) begin
                    if (rx_state == 0) m_rxb = reg_wdata & 32'hFFFF_FFFC; else rej = 1;
                end else if (reg_addr == 8'h20) begin
                    if (tx_state == 0) m_txb = reg_wdata & 32'hFFFF_FFFC; else rej = 1;
                end
            end
            m_cnt = next_cnt;
            m_rej = rej;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input logic [7:0] a);
        case (a)
            8'h00: return {24'h0, m_be, m_skip, m_pr, (m_cnt > 0)};
            8'h08, 8'h10: return 32'hFFFF_FFFF;
            8'h18: return m_rxb;
            8'h20: return m_txb;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_req(input logic [7:0] a);
        case (a)
            8'h00: return "R2 rdata";
            8'h08, 8'h10: return "R7 rdata";
            8'h18, 8'h20: return "R8 rdata";
            default: return "R10 rdata";
        endcase
    endfunction

    task automatic compare_all();
        logic [31:0] e;
        e = exp_rdata(reg_addr);
        check(reg_rdata === e, rd_req(reg_addr), reg_rdata, e);
        check({big_endian, skip_len, tx_priority} === {m_be, m_skip, m_pr}, "R2 fields",
              {25'h0, big_endian, skip_len, tx_priority}, {25'h0, m_be, m_skip, m_pr});
        check(soft_reset === (m_cnt > 0), "R3 soft_reset", {31'h0, soft_reset}, {31'h0, m_cnt > 0});
        check(tx_kick === m_txk, "R5 tx_kick", {31'h0, tx_kick}, {31'h0, m_txk});
        check(rx_kick === m_rxk, "R6 rx_kick", {31'h0, rx_kick}, {31'h0, m_rxk});
        check(rx_desc_base === m_rxb, "R8 rx base", rx_desc_base, m_rxb);
        check(tx_desc_base === m_txb, "R8 tx base", tx_desc_base, m_txb);
        check(wr_reject === m_rej, "R9 wr_reject", {31'h0, wr_reject}, {31'h0, m_rej});
    endtask

    // one cycle of stimulus, compared after the inputs settle
    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [1:0] ts, input logic [1:0] rs);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; tx_state = ts; rx_state = rs;
        #2;
        compare_all();
    endtask

    // watchdog
    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        check({big_endian, skip_len, tx_priority, soft_reset, tx_kick, rx_kick, wr_reject} === '0,
              "R1 reset outputs", {21'h0, big_endian, skip_len, tx_priority, soft_reset, tx_kick, rx_kick, wr_reject}, 32'h0);
        check(rx_desc_base === 0 && tx_desc_base === 0, "R1 reset bases", rx_desc_base | tx_desc_base, 32'h0);

        // R2: accepted and rejected configuration writes
        step(1, 8'h00, 32'h0000_008E, 0, 0);
        step(0, 8'h00, 0, 0, 0);
        check(big_endian === 1 && skip_len === 5'd3 && tx_priority === 1, "R2 directed load",
              {25'h0, big_endian, skip_len, tx_priority}, 32'h0000_0047);
        step(1, 8'h00, 32'h0000_0000, 1, 0);
        step(0, 8'h00, 0, 0, 0);
        check(wr_reject === 1 && skip_len === 5'd3, "R9 directed reject", {31'h0, wr_reject}, 32'h1);

        // R8: base writes with low bits set
        step(1, 8'h18, 32'hDEAD_BEEF, 0, 0);
        step(1, 8'h20, 32'h1234_5677, 0, 0);
        step(1, 8'h20, 32'hFFFF_FFFF, 2, 0);
        step(0, 8'h20, 0, 0, 0);
        check(tx_desc_base === 32'h1234_5674 && rx_desc_base === 32'hDEAD_BEEC, "R8 directed",
              tx_desc_base, 32'h1234_5674);

        // R3 and R4: software reset window
        step(1, 8'h00, 32'h0000_0015, 0, 0);
        for (int i = 0; i < 20; i++)
            step(i == 4, 8'h00, 32'h0000_00FF, 0, 0);
        check(skip_len === 5'd5 && tx_desc_base === 32'h1234_5674, "R4 kept after reset",
              {27'h0, skip_len}, 32'h5);

        // R5, R6: kicks in each engine state
        step(1, 8'h08, 32'h0, 2, 0);
        step(1, 8'h08, 32'h5A5A_5A5A, 1, 2);
        step(1, 8'h10, 32'h0, 1, 2);
        step(1, 8'h10, 32'h0, 2, 3);
        step(0, 8'h10, 0, 0, 0);

        // R10: unmapped offsets
        step(1, 8'h28, 32'hFFFF_FFFF, 0, 0);
        step(1, 8'h04, 32'hFFFF_FFFF, 0, 0);
        step(0, 8'h04, 0, 0, 0);
        check(wr_reject === 0 && reg_rdata === 0, "R10 directed", {31'h0, wr_reject}, 32'h0);

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            case ($urandom_range(0, 6))
                0: a = 8'h00; 1: a = 8'h08; 2: a = 8'h10; 3: a = 8'h18;
                4: a = 8'h20; 5: a = 8'h0C; default: a = 8'h30;
            endcase
            step($urandom_range(0, 1) == 1, a, $urandom,
                 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
        end
        step(0, 8'h00, 0, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule